// File: doc/BRIEF.md
# Strap-Configured Host Address Decoder

This block sets up a host-bus slave once per reset from a configuration word read off its data pins. While reset is asserted, the pins are sampled on every clock edge. The value present at the last edge before reset falls is kept until the next reset. From that word the block takes four mode flags: host bus width, I/O mapping style, handshake style and byte swap. It also takes a 9-bit I/O base and a 3-bit memory window base.

After reset, every host cycle is decoded combinationally into two enables.
- The I/O enable compares address bits 9..1 against the I/O base while the I/O chip select is low. In index-register mode all nine bits must match, and address bit 0 picks the index port or the data port. In direct-mapped mode the lowest three compared bits are left out of the match and passed out as a register offset.
- The memory enable compares address bits 19..17 against the memory base while the memory chip select is low. This gives a 128 KB window.

A data path reverses the two bytes of the host data word only when the 16-bit and swap flags are both set.

Top module: `strap_addr_decoder`

## Requirements
- R1: While `rst` is high the strap register loads `strap_i` on every rising clock edge; while `rst` is low it holds, so strap pin changes after reset have no effect on flags or decoding.
- R2: `mode_bus16` equals latched strap bit 0 (1 = 16-bit host bus, 0 = 8-bit).
- R3: `mode_direct` equals latched strap bit 1 (1 = direct-mapped I/O registers, 0 = internal index register).
- R4: `mode_m68k` equals latched strap bit 2 (1 = 68000-style handshake, 0 = READY/WAIT bus).
- R5: `mode_swap` equals latched strap bit 3 (1 = byte swap requested).
- R6: In index mode `io_sel` is 1 exactly when `iocs_n` is 0 and `haddr_i[9:1]` equals latched strap bits 12..4; `io_data_port` equals `haddr_i[0]` and `io_reg_ofs` is 0.
- R7: In direct mode `io_sel` is 1 exactly when `iocs_n` is 0 and `haddr_i[9:4]` equals latched strap bits 12..7; `io_reg_ofs` equals `haddr_i[3:1]` and `io_data_port` is 0.
- R8: `mem_sel` is 1 exactly when `memcs_n` is 0 and `haddr_i[19:17]` equals latched strap bits 15..13.
- R9: While `rst` is high, `io_sel` and `mem_sel` are 0 whatever the address and chip selects.
- R10: `hdata_o` is `hdata_i` with its two bytes exchanged when `mode_bus16` and `mode_swap` are both 1, and equal to `hdata_i` otherwise.
- R11: A strap word of all zeros (pins left to their pull-downs) gives all four mode flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used to sample the straps during reset |
| rst | input | 1 | Active-high reset; the straps are held from its falling edge |
| strap_i | input | 16 | Configuration pins (the shared data pins) |
| haddr_i | input | 20 | Host address; bit 0 selects the port in index mode |
| iocs_n | input | 1 | Active-low I/O chip select |
| memcs_n | input | 1 | Active-low memory chip select |
| hdata_i | input | 16 | Host data into the byte lane steering |
| mode_bus16 | output | 1 | Latched 16-bit bus flag |
| mode_direct | output | 1 | Latched direct-mapped I/O flag |
| mode_m68k | output | 1 | Latched 68000 handshake flag |
| mode_swap | output | 1 | Latched byte swap flag |
| io_sel | output | 1 | I/O decoder enable |
| io_reg_ofs | output | 3 | Register offset in direct mode |
| io_data_port | output | 1 | Data port (1) or index port (0) in index mode |
| mem_sel | output | 1 | Memory decoder enable |
| hdata_o | output | 16 | Host data after byte steering |

## Verification
The clocked assertions assume that address, chip selects and data are steady at each rising edge. They also assume that the strap pins have settled by the last edge before reset falls. Nothing is assumed about when the strap pins change after that. The bench changes every input only just after a falling clock edge, then checks before the next rising edge. Each configuration is applied through a complete reset sequence, so the strap register always holds a clean value when the decode sweeps run.

// File: rtl/sad_pkg.sv
package sad_pkg;

   // Flag positions inside the strap word; a neighbouring block decodes them.
   localparam int unsigned FLAG_BUS16  = 0;
   localparam int unsigned FLAG_DIRECT = 1;
   localparam int unsigned FLAG_M68K   = 2;
   localparam int unsigned FLAG_SWAP   = 3;
   localparam int unsigned NUM_FLAGS   = 4;

   typedef struct packed {
      logic swap;
      logic m68k;
      logic direct;
      logic bus16;
   } mode_t;

   function automatic mode_t unpack_mode(input logic [NUM_FLAGS-1:0] raw);
      mode_t m;
      m.bus16  = raw[FLAG_BUS16];
      m.direct = raw[FLAG_DIRECT];
      m.m68k   = raw[FLAG_M68K];
      m.swap   = raw[FLAG_SWAP];
      return m;
   endfunction

endpackage

// File: rtl/sad_strap_latch.sv
module sad_strap_latch #(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] pins_i,
   output logic [WIDTH-1:0] word_o
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("sad_strap_latch: WIDTH must be at least 1");
      end
   endgenerate

   // Track the pins throughout reset; the last sample before release is kept.
   always_ff @(posedge clk) begin
      if (rst) begin
         word_o <= pins_i;
      end
   end

   a_r1_hold_after_reset: assert property (
      @(posedge clk) disable iff (rst) 1'b1 |=> $stable(word_o)
   );

endmodule

// File: rtl/sad_io_decode.sv
module sad_io_decode #(
   parameter int unsigned CMP_W = 9,
   parameter int unsigned OFS_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             direct_i,
   input  logic [CMP_W-1:0] base_i,
   input  logic [CMP_W-1:0] field_i,
   input  logic             a0_i,
   input  logic             cs_n_i,
   output logic             sel_o,
   output logic [OFS_W-1:0] ofs_o,
   output logic             port_o
);

   localparam int unsigned        HI_W     = CMP_W - OFS_W;
   localparam logic [CMP_W-1:0]   HI_MASK  = {{HI_W{1'b1}}, {OFS_W{1'b0}}};

   generate
      if (OFS_W >= CMP_W) begin : g_bad_ofs
         $error("sad_io_decode: OFS_W must be below CMP_W");
      end
   endgenerate

   logic match_full;
   logic match_high;
   logic match;

   always_comb begin
      match_full = (field_i == base_i);
      match_high = ((field_i & HI_MASK) == (base_i & HI_MASK));
      match      = direct_i ? match_high : match_full;
      sel_o      = !rst && !cs_n_i && match;
      ofs_o      = direct_i ? field_i[OFS_W-1:0] : '0;
      port_o     = direct_i ? 1'b0 : a0_i;
   end

   a_r6_sel_needs_cs: assert property (
      @(posedge clk) disable iff (rst) sel_o |-> !cs_n_i
   );

   a_r6_index_full_match: assert property (
      @(posedge clk) disable iff (rst) (sel_o && !direct_i) |-> (field_i == base_i)
   );

   a_r7_offset_only_direct: assert property (
      @(posedge clk) disable iff (rst) !direct_i |-> (ofs_o == '0)
   );

   a_r7_port_only_index: assert property (
      @(posedge clk) disable iff (rst) direct_i |-> !port_o
   );

endmodule

// File: rtl/sad_mem_decode.sv
module sad_mem_decode #(
   parameter int unsigned CMP_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CMP_W-1:0] base_i,
   input  logic [CMP_W-1:0] field_i,
   input  logic             cs_n_i,
   output logic             sel_o
);

   generate
      if (CMP_W < 1) begin : g_bad_cmp
         $error("sad_mem_decode: CMP_W must be at least 1");
      end
   endgenerate

   always_comb begin
      sel_o = !rst && !cs_n_i && (field_i == base_i);
   end

   a_r8_sel_needs_cs: assert property (
      @(posedge clk) disable iff (rst) sel_o |-> !cs_n_i
   );

   a_r8_sel_needs_match: assert property (
      @(posedge clk) disable iff (rst) sel_o |-> (field_i == base_i)
   );

endmodule

// File: rtl/sad_byte_lane.sv
module sad_byte_lane #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              swap_en_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] data_o
);

   localparam int unsigned NUM_BYTES = DATA_W / 8;

   generate
      if ((DATA_W % 8) != 0 || NUM_BYTES < 2) begin : g_bad_width
         $error("sad_byte_lane: DATA_W must be a multiple of 8, at least 16");
      end
   endgenerate

   // Byte k of the output takes byte (NUM_BYTES-1-k) when swapping.
   for (genvar k = 0; k < NUM_BYTES; k++) begin : g_lane
      always_comb begin
         data_o[k*8 +: 8] = swap_en_i ? data_i[(NUM_BYTES-1-k)*8 +: 8]
                                      : data_i[k*8 +: 8];
      end
   end

endmodule

// File: rtl/strap_addr_decoder.sv
module strap_addr_decoder #(
   parameter int unsigned ADDR_W   = 20,
   parameter int unsigned IO_LSB   = 1,
   parameter int unsigned IO_W     = 9,
   parameter int unsigned MEM_W    = 3,
   parameter int unsigned OFS_W    = 3,
   parameter int unsigned DATA_W   = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] strap_i,
   input  logic [ADDR_W-1:0] haddr_i,
   input  logic              iocs_n,
   input  logic              memcs_n,
   input  logic [DATA_W-1:0] hdata_i,
   output logic              mode_bus16,
   output logic              mode_direct,
   output logic              mode_m68k,
   output logic              mode_swap,
   output logic              io_sel,
   output logic [OFS_W-1:0]  io_reg_ofs,
   output logic              io_data_port,
   output logic              mem_sel,
   output logic [DATA_W-1:0] hdata_o
);

   import sad_pkg::*;

   localparam int unsigned STRAP_W  = NUM_FLAGS + IO_W + MEM_W;
   localparam int unsigned IO_BLSB  = NUM_FLAGS;
   localparam int unsigned MEM_BLSB = NUM_FLAGS + IO_W;
   localparam int unsigned MEM_ALSB = ADDR_W - MEM_W;
   localparam int unsigned GAP_LSB  = IO_LSB + IO_W;
   localparam int unsigned GAP_W    = MEM_ALSB - GAP_LSB;

   generate
      if (STRAP_W != DATA_W) begin : g_bad_strap
         $error("strap_addr_decoder: flag, I/O and memory fields must fill the data pins");
      end
      if (IO_LSB != 1) begin : g_bad_lsb
         $error("strap_addr_decoder: I/O compare must start at address bit 1");
      end
      if (GAP_LSB > MEM_ALSB) begin : g_bad_overlap
         $error("strap_addr_decoder: I/O and memory compare fields overlap");
      end
   endgenerate

   logic [STRAP_W-1:0] strap_q;
   mode_t              mode;

   sad_strap_latch #(.WIDTH(STRAP_W)) i_latch (
      .clk    (clk),
      .rst    (rst),
      .pins_i (strap_i),
      .word_o (strap_q)
   );

   always_comb begin
      mode        = unpack_mode(strap_q[NUM_FLAGS-1:0]);
      mode_bus16  = mode.bus16;
      mode_direct = mode.direct;
      mode_m68k   = mode.m68k;
      mode_swap   = mode.swap;
   end

   sad_io_decode #(.CMP_W(IO_W), .OFS_W(OFS_W)) i_io (
      .clk      (clk),
      .rst      (rst),
      .direct_i (mode.direct),
      .base_i   (strap_q[IO_BLSB +: IO_W]),
      .field_i  (haddr_i[IO_LSB +: IO_W]),
      .a0_i     (haddr_i[0]),
      .cs_n_i   (iocs_n),
      .sel_o    (io_sel),
      .ofs_o    (io_reg_ofs),
      .port_o   (io_data_port)
   );

   sad_mem_decode #(.CMP_W(MEM_W)) i_mem (
      .clk     (clk),
      .rst     (rst),
      .base_i  (strap_q[MEM_BLSB +: MEM_W]),
      .field_i (haddr_i[MEM_ALSB +: MEM_W]),
      .cs_n_i  (memcs_n),
      .sel_o   (mem_sel)
   );

   logic swap_en;
   always_comb swap_en = mode.bus16 && mode.swap;

   sad_byte_lane #(.DATA_W(DATA_W)) i_lane (
      .swap_en_i (swap_en),
      .data_i    (hdata_i),
      .data_o    (hdata_o)
   );

   generate
      if (GAP_W > 0) begin : g_gap
         logic unused_addr_gap;
         assign unused_addr_gap = ^haddr_i[GAP_LSB +: GAP_W];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         a_r9_idle_in_reset: assert (!io_sel && !mem_sel);
      end
   end

   a_r10_no_swap_passthru: assert property (
      @(posedge clk) disable iff (rst) !(mode_bus16 && mode_swap) |-> (hdata_o == hdata_i)
   );

   a_r10_swap_reverses: assert property (
      @(posedge clk) disable iff (rst)
         (mode_bus16 && mode_swap) |-> (hdata_o[7:0] == hdata_i[DATA_W-1 -: 8])
   );

endmodule

// File: tb/test_strap_addr_decoder.sv
module test_strap_addr_decoder;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] strap_i = '0;
   logic [19:0] haddr_i = '0;
   logic        iocs_n = 1'b1;
   logic        memcs_n = 1'b1;
   logic [15:0] hdata_i = '0;
   logic        mode_bus16, mode_direct, mode_m68k, mode_swap;
   logic        io_sel, io_data_port, mem_sel;
   logic [2:0]  io_reg_ofs;
   logic [15:0] hdata_o;

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;
   bit done    = 1'b0;

   strap_addr_decoder i_strap_addr_decoder (
      .clk(clk), .rst(rst), .strap_i(strap_i), .haddr_i(haddr_i),
      .iocs_n(iocs_n), .memcs_n(memcs_n), .hdata_i(hdata_i),
      .mode_bus16(mode_bus16), .mode_direct(mode_direct),
      .mode_m68k(mode_m68k), .mode_swap(mode_swap),
      .io_sel(io_sel), .io_reg_ofs(io_reg_ofs), .io_data_port(io_data_port),
      .mem_sel(mem_sel), .hdata_o(hdata_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > WATCHDOG && !done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog: got %0d cycles expected below %0d", cycles, WATCHDOG);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic do_reset(input logic [15:0] word);
      @(negedge clk);
      rst = 1'b1; strap_i = word;
      iocs_n = 1'b0; memcs_n = 1'b0;
      haddr_i = {word[15:13], 7'd0, word[12:4], 1'b0};
      #1;
      check("R9 io_sel low in reset", io_sel, 0);
      check("R9 mem_sel low in reset", mem_sel, 0);
      repeat (2) @(negedge clk);
      rst = 1'b0; iocs_n = 1'b1; memcs_n = 1'b1;
      #1;
   endtask

   task automatic check_flags(input logic [15:0] word);
      check("R2 bus16",  mode_bus16,  word[0]);
      check("R3 direct", mode_direct, word[1]);
      check("R4 m68k",   mode_m68k,   word[2]);
      check("R5 swap",   mode_swap,   word[3]);
   endtask

   task automatic sweep_io(input logic [15:0] word);
      logic [8:0] base;
      logic       exp_sel;
      base = word[12:4];
      memcs_n = 1'b1;
      for (int a = 0; a < 512; a++) begin
         for (int c = 0; c < 2; c++) begin
            @(negedge clk);
            haddr_i = {3'b000, 7'h55, a[8:0], a[0] ^ c[0]};
            iocs_n  = c[0];
            #1;
            if (word[1]) begin
               exp_sel = !c[0] && (a[8:3] == base[8:3]);
               check("R7 direct io_sel", io_sel, exp_sel);
               check("R7 direct offset", io_reg_ofs, a[2:0]);
               check("R7 direct port",   io_data_port, 0);
            end else begin
               exp_sel = !c[0] && (a[8:0] == base);
               check("R6 index io_sel", io_sel, exp_sel);
               check("R6 index offset", io_reg_ofs, 0);
               check("R6 index port",   io_data_port, a[0] ^ c[0]);
            end
            check("R8 mem_sel idle", mem_sel, 0);
         end
      end
   endtask

   task automatic sweep_mem(input logic [15:0] word);
      iocs_n = 1'b1;
      for (int m = 0; m < 8; m++) begin
         for (int c = 0; c < 2; c++) begin
            @(negedge clk);
            haddr_i = {m[2:0], 17'h0A5A5};
            memcs_n = c[0];
            #1;
            check("R8 mem_sel", mem_sel, !c[0] && (m[2:0] == word[15:13]));
            check("R8 io_sel idle", io_sel, 0);
         end
      end
      memcs_n = 1'b1;
   endtask

   task automatic check_lane(input logic [15:0] word);
      logic [15:0] pats [4];
      pats[0] = 16'h12AB; pats[1] = 16'hFF00; pats[2] = 16'h0001; pats[3] = 16'hC35A;
      foreach (pats[i]) begin
         @(negedge clk);
         hdata_i = pats[i];
         #1;
         if (word[0] && word[3])
            check("R10 swapped", hdata_o, {pats[i][7:0], pats[i][15:8]});
         else
            check("R10 straight", hdata_o, pats[i]);
      end
   endtask

   initial begin
      logic [15:0] w;

      // R11: pins at their pull-down level
      do_reset(16'h0000);
      check("R11 bus16 clear",  mode_bus16,  0);
      check("R11 direct clear", mode_direct, 0);
      check("R11 m68k clear",   mode_m68k,   0);
      check("R11 swap clear",   mode_swap,   0);

      for (int cfg = 0; cfg < 16; cfg++) begin
         for (int b = 0; b < 2; b++) begin
            logic [8:0] base;
            base = (b == 0) ? 9'h180 : 9'((cfg * 37 + 5) & 9'h1FF);
            w = {cfg[2:0] ^ 3'b101, base, cfg[3:0]};
            do_reset(w);
            check_flags(w);
            sweep_io(w);
            sweep_mem(w);
            check_lane(w);
         end
      end

      // R1: strap pins change after reset; nothing follows them
      w = {3'b101, 9'h180, 4'b1010};
      do_reset(w);
      @(negedge clk);
      strap_i = ~w;
      repeat (3) @(negedge clk);
      #1;
      check("R1 flags held", {mode_swap, mode_m68k, mode_direct, mode_bus16}, w[3:0]);
      iocs_n  = 1'b0;
      haddr_i = {3'b101, 7'd0, 9'h180, 1'b0};
      #1;
      check("R1 io base held", io_sel, 1);
      iocs_n = 1'b1; memcs_n = 1'b0;
      #1;
      check("R1 mem base held", mem_sel, 1);
      memcs_n = 1'b1;

      // R1: a new reset picks up the new pin value
      do_reset(~w);
      check_flags(~w);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule